// File: doc/BRIEF.md
# Receive Cell Interrupt Status Controller

This block collects the interrupt events of an ATM receive cell processor and presents them to a local microprocessor through two levels of status. Three event pulses (header error check failure, OAM cell arrival, loss of cell delineation) are each caught in a sticky detail bit. Each detail bit can raise an interrupt only when its enable bit is set. The enabled pending bits are ORed into one bit of an 8-bit top-level summary register. The other bits of that register carry the level summaries of the neighbouring receive and transmit blocks and a latched one-second tick.

Interrupt service software reads the summary register first. A 1 in bit 5 points it to the detail register, which it reads next to find the source. Reading the detail register clears it. In the summary register only the one-second bit clears when read. The other summary bits follow their sources.

Top module: `rx_cell_irq_ctrl`

## Requirements
- R1: After reset, every detail, enable and one-second bit is 0, `reg_rdata` is 0x00 and `irq` is low.
- R2: A one-cycle pulse on `hec_err_pulse`, `oam_cell_pulse` or `lcd_loss_pulse` sets detail bit 0, 1 or 2 respectively, whatever the enable setting, and the bit stays set until the detail register is read.
- R3: The enable register at address 0x4E is written with `reg_wr`. Bits 2:0 enable the sources in the same order as the detail bits. A read returns those bits, with bits 7:3 as 0.
- R4: A read of the detail register at 0x4F returns the detail bits in bits 2:0, with bits 7:3 as 0, and clears all detail bits.
- R5: An event pulse in the same cycle as a detail register read leaves its bit set afterwards. The data returned by that read is the value before the event.
- R6: Summary bit 5 is 1 exactly when some detail bit and its enable bit are both 1. A latched but disabled source affects neither bit 5 nor `irq`.
- R7: The summary register is at address 0x05. Bits 7, 6, 4, 3, 2 and 1 show `peer_irq[5]`, `peer_irq[4]`, `peer_irq[3]`, `peer_irq[2]`, `peer_irq[1]` and `peer_irq[0]` (receive line, receive convergence, receive cell bus, transmit cell bus, transmit cell processor, transmit line). They are read-only and a read does not change them.
- R8: Summary bit 0 latches a pulse on `one_sec_tick` and clears when the summary register is read. A tick in the same cycle as that read stays latched.
- R9: `irq` is active high and equals the OR of all eight summary bits in the same cycle.
- R10: Writes to 0x05, to 0x4F or to any unmapped address change nothing. Reads of unmapped addresses return 0x00.
- R11: `reg_rdata` takes its new value on the clock edge that samples `reg_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hec_err_pulse | input | 1 | Header error check failure event |
| oam_cell_pulse | input | 1 | OAM cell received event |
| lcd_loss_pulse | input | 1 | Loss of cell delineation event |
| peer_irq | input | 6 | Interrupt summary levels of the neighbouring blocks |
| one_sec_tick | input | 1 | One-second tick pulse |
| reg_addr | input | 8 | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
An event pulse or a tick is visible in the state one edge after it is sampled. `irq` follows that state in the same cycle, and it follows `peer_irq` with no delay. Read data comes from the edge that samples the strobe, and the clear caused by the read happens on that same edge. The bench drives inputs 2 ns after a rising edge. A behavioural model is advanced on each rising edge, and `reg_rdata` and `irq` are compared with it at each falling edge. The explicit register reads are checked 7 ns after the edge that captured them. The same-cycle collisions of R5 and R8 are checked both in the returned value and in the value of the following read.

// File: rtl/rcirq_pkg.sv
package rcirq_pkg;
    localparam int NUM_SRC    = 3;
    localparam int SRC_HEC    = 0;
    localparam int SRC_OAM    = 1;
    localparam int SRC_LCD    = 2;
    localparam int NUM_PEER   = 6;
    localparam int DATA_W     = 8;
    localparam int RXCP_BIT   = 5;
    localparam int ONESEC_BIT = 0;

    typedef logic [NUM_SRC-1:0]  src_vec_t;
    typedef logic [NUM_PEER-1:0] peer_vec_t;
    typedef logic [DATA_W-1:0]   byte_t;
endpackage

// File: rtl/rcirq_sticky.sv
module rcirq_sticky #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } sticky_t;

    sticky_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.bits = '0;
        // a set in the clearing cycle wins
        st_d.bits = st_d.bits | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;
endmodule

// File: rtl/rcirq_summary.sv
module rcirq_summary
    import rcirq_pkg::*;
(
    input  src_vec_t  detail_i,
    input  src_vec_t  enable_i,
    input  peer_vec_t peer_i,
    input  logic      onesec_i,
    output byte_t     summary_o,
    output logic      irq_o
);
    logic rxcp_pend;

    always_comb begin
        rxcp_pend = |(detail_i & enable_i);
        summary_o = '0;
        summary_o[7]          = peer_i[5];
        summary_o[6]          = peer_i[4];
        summary_o[RXCP_BIT]   = rxcp_pend;
        summary_o[4:1]        = peer_i[3:0];
        summary_o[ONESEC_BIT] = onesec_i;
        irq_o = |summary_o;
    end
endmodule

// File: rtl/rcirq_regif.sv
module rcirq_regif
    import rcirq_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SUM_ADDR = 8'h05,
    parameter logic [ADDR_W-1:0] DET_ADDR = 8'h4F,
    parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h4E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  byte_t             wdata_i,
    input  src_vec_t          detail_i,
    input  byte_t             summary_i,
    output src_vec_t          enable_o,
    output logic              clr_detail_o,
    output logic              clr_onesec_o,
    output byte_t             rdata_o
);
    typedef struct packed {
        src_vec_t en;
        byte_t    rdata;
    } regif_t;

    regif_t st_d, st_q;
    byte_t  det_ext, en_ext;

    always_comb begin
        st_d         = st_q;
        clr_detail_o = 1'b0;
        clr_onesec_o = 1'b0;
        det_ext      = '0;
        det_ext[NUM_SRC-1:0] = detail_i;
        en_ext       = '0;
        en_ext[NUM_SRC-1:0]  = st_q.en;

        if (wr_i && addr_i == EN_ADDR) st_d.en = wdata_i[NUM_SRC-1:0];

        if (rd_i) begin
            if (addr_i == SUM_ADDR) begin
                st_d.rdata   = summary_i;
                clr_onesec_o = 1'b1;
            end else if (addr_i == DET_ADDR) begin
                st_d.rdata   = det_ext;
                clr_detail_o = 1'b1;
            end else if (addr_i == EN_ADDR) begin
                st_d.rdata   = en_ext;
            end else begin
                st_d.rdata   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_o = st_q.en;
    assign rdata_o  = st_q.rdata;
endmodule

// File: rtl/rx_cell_irq_ctrl.sv
module rx_cell_irq_ctrl
    import rcirq_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SUM_ADDR = 8'h05,
    parameter logic [ADDR_W-1:0] DET_ADDR = 8'h4F,
    parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h4E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hec_err_pulse,
    input  logic              oam_cell_pulse,
    input  logic              lcd_loss_pulse,
    input  logic [5:0]        peer_irq,
    input  logic              one_sec_tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    src_vec_t events, detail_q, enable_q;
    logic     onesec_q, clr_detail, clr_onesec;
    byte_t    summary;

    always_comb begin
        events          = '0;
        events[SRC_HEC] = hec_err_pulse;
        events[SRC_OAM] = oam_cell_pulse;
        events[SRC_LCD] = lcd_loss_pulse;
    end

    rcirq_sticky #(.W(NUM_SRC)) u_detail (
        .clk(clk), .rst_n(rst_n), .set_i(events),
        .clr_i(clr_detail), .q_o(detail_q)
    );

    rcirq_sticky #(.W(1)) u_onesec (
        .clk(clk), .rst_n(rst_n), .set_i(one_sec_tick),
        .clr_i(clr_onesec), .q_o(onesec_q)
    );

    rcirq_summary u_summary (
        .detail_i(detail_q), .enable_i(enable_q), .peer_i(peer_irq),
        .onesec_i(onesec_q), .summary_o(summary), .irq_o(irq)
    );

    rcirq_regif #(
        .ADDR_W(ADDR_W), .SUM_ADDR(SUM_ADDR),
        .DET_ADDR(DET_ADDR), .EN_ADDR(EN_ADDR)
    ) u_regif (
        .clk(clk), .rst_n(rst_n), .addr_i(reg_addr), .rd_i(reg_rd),
        .wr_i(reg_wr), .wdata_i(reg_wdata), .detail_i(detail_q),
        .summary_i(summary), .enable_o(enable_q),
        .clr_detail_o(clr_detail), .clr_onesec_o(clr_onesec),
        .rdata_o(reg_rdata)
    );
endmodule

// File: rtl/rcirq_checker.sv
module rcirq_checker #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SUM_ADDR = 8'h05,
    parameter logic [ADDR_W-1:0] DET_ADDR = 8'h4F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hec_err_pulse,
    input logic              oam_cell_pulse,
    input logic              lcd_loss_pulse,
    input logic [5:0]        peer_irq,
    input logic              one_sec_tick,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [7:0]        reg_rdata,
    input logic              irq,
    input logic [2:0]        detail_q,
    input logic [2:0]        enable_q,
    input logic              onesec_q
);
    logic any_evt, det_rd, sum_rd;
    assign any_evt = hec_err_pulse | oam_cell_pulse | lcd_loss_pulse;
    assign det_rd  = reg_rd && reg_addr == DET_ADDR;
    assign sum_rd  = reg_rd && reg_addr == SUM_ADDR;

    a_r2_hec_latch: assert property (@(posedge clk) disable iff (!rst_n)
        hec_err_pulse |=> detail_q[0]);
    a_r2_oam_latch: assert property (@(posedge clk) disable iff (!rst_n)
        oam_cell_pulse |=> detail_q[1]);
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (det_rd && !any_evt) |=> detail_q == 3'b000);
    a_r4_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        det_rd |=> reg_rdata == {5'b0, $past(detail_q)});
    a_r5_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (det_rd && lcd_loss_pulse) |=> detail_q[2]);
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_irq == 6'd0 && !onesec_q && (detail_q & enable_q) == 3'b000) |-> !irq);
    a_r9_irq_onesec: assert property (@(posedge clk) disable iff (!rst_n)
        onesec_q |-> irq);
    a_r8_tick_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_rd && one_sec_tick) |=> onesec_q);
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_rd && !one_sec_tick) |=> !onesec_q);
    a_r10_detail_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && !any_evt) |=> detail_q == $past(detail_q));
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind rx_cell_irq_ctrl rcirq_checker #(
    .ADDR_W(ADDR_W), .SUM_ADDR(SUM_ADDR), .DET_ADDR(DET_ADDR)
) u_rcirq_checker (
    .clk(clk), .rst_n(rst_n), .hec_err_pulse(hec_err_pulse),
    .oam_cell_pulse(oam_cell_pulse), .lcd_loss_pulse(lcd_loss_pulse),
    .peer_irq(peer_irq), .one_sec_tick(one_sec_tick), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq(irq),
    .detail_q(detail_q), .enable_q(enable_q), .onesec_q(onesec_q)
);

// File: tb/tb_rx_cell_irq_ctrl.sv
`timescale 1ns/1ps
module tb_rx_cell_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hec = 1'b0, oam = 1'b0, lcd = 1'b0, tick = 1'b0;
    logic [5:0] peer = '0;
    logic [7:0] addr = '0, wdata = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int    checks = 0, failures = 0, cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic [7:0] m_det = '0, m_en = '0, m_rdata = '0;
    logic       m_os = 1'b0;

    always #10 clk = ~clk;

    rx_cell_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hec_err_pulse(hec), .oam_cell_pulse(oam),
        .lcd_loss_pulse(lcd), .peer_irq(peer), .one_sec_tick(tick),
        .reg_addr(addr), .reg_rd(rd), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq(irq)
    );

    function automatic logic [7:0] m_summary();
        logic [7:0] s;
        s = {peer[5], peer[4], ((m_det & m_en) != 0), peer[3:0], m_os};
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_det = '0; m_en = '0; m_rdata = '0; m_os = 1'b0;
        end else begin
            logic [7:0] nd, ns;
            nd = m_det; ns = {7'd0, m_os};
            if (rd) begin
                case (addr)
                    8'h05: begin m_rdata = m_summary(); ns = '0; end
                    8'h4F: begin m_rdata = m_det; nd = '0; end
                    8'h4E: m_rdata = m_en;
                    default: m_rdata = '0;
                endcase
            end
            if (wr && addr == 8'h4E) m_en = wdata & 8'h07;
            m_det = nd | {5'd0, lcd, oam, hec};
            m_os  = ns[0] | tick;
        end
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(rdata == m_rdata, cur_req, rdata, m_rdata);
            check(irq == (m_summary() != 0), cur_req, irq, m_summary() != 0);
        end
    end

    task automatic next();
        @(posedge clk); #2;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [7:0] exp, input string req);
        addr = a; rd = 1'b1; next(); rd = 1'b0; #5;
        check(rdata == exp, req, rdata, exp);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1; next(); wr = 1'b0;
    endtask

    task automatic irq_expect(input logic exp, input string req);
        #5; check(irq == exp, req, irq, exp);
    endtask

    initial begin
        repeat (3) next();
        rst_n = 1'b1; next();
        // R1 reset state
        cur_req = "R1";
        check(rdata == 8'h00, "R1", rdata, 0);
        irq_expect(1'b0, "R1");
        rd_expect(8'h05, 8'h00, "R1");
        rd_expect(8'h4F, 8'h00, "R1");
        rd_expect(8'h4E, 8'h00, "R1");
        // R3 enable register
        cur_req = "R3";
        wr_reg(8'h4E, 8'h05); rd_expect(8'h4E, 8'h05, "R3");
        wr_reg(8'h4E, 8'hFF); rd_expect(8'h4E, 8'h07, "R3");
        wr_reg(8'h4E, 8'h00); rd_expect(8'h4E, 8'h00, "R3");
        // R2 latching with sources disabled, R6 masking
        cur_req = "R2";
        hec = 1'b1; next(); hec = 1'b0;
        irq_expect(1'b0, "R6");
        rd_expect(8'h05, 8'h00, "R6");
        rd_expect(8'h4F, 8'h01, "R2");
        cur_req = "R4";
        rd_expect(8'h4F, 8'h00, "R4");
        cur_req = "R6";
        oam = 1'b1; next(); oam = 1'b0;
        lcd = 1'b1; next(); lcd = 1'b0;
        irq_expect(1'b0, "R6");
        wr_reg(8'h4E, 8'h02);
        irq_expect(1'b1, "R9");
        rd_expect(8'h05, 8'h20, "R6");
        cur_req = "R4";
        rd_expect(8'h4F, 8'h06, "R4");
        irq_expect(1'b0, "R4");
        rd_expect(8'h4F, 8'h00, "R4");
        // R5 event during detail read
        cur_req = "R5";
        hec = 1'b1; next(); hec = 1'b0;
        lcd = 1'b1; addr = 8'h4F; rd = 1'b1; next(); rd = 1'b0; lcd = 1'b0; #5;
        check(rdata == 8'h01, "R5", rdata, 8'h01);
        rd_expect(8'h4F, 8'h04, "R5");
        // R7 peer summaries
        cur_req = "R7";
        peer = 6'b100001; next();
        irq_expect(1'b1, "R9");
        rd_expect(8'h05, 8'h82, "R7");
        rd_expect(8'h05, 8'h82, "R7");
        peer = 6'b011110; next();
        rd_expect(8'h05, 8'h5C, "R7");
        peer = 6'b000000; next();
        irq_expect(1'b0, "R9");
        // R8 one-second bit
        cur_req = "R8";
        tick = 1'b1; next(); tick = 1'b0;
        irq_expect(1'b1, "R8");
        rd_expect(8'h05, 8'h01, "R8");
        rd_expect(8'h05, 8'h00, "R8");
        tick = 1'b1; addr = 8'h05; rd = 1'b1; next(); rd = 1'b0; tick = 1'b0; #5;
        check(rdata == 8'h00, "R8", rdata, 0);
        rd_expect(8'h05, 8'h01, "R8");
        // R10 ignored writes and unmapped reads
        cur_req = "R10";
        hec = 1'b1; next(); hec = 1'b0;
        wr_reg(8'h4F, 8'h00);
        wr_reg(8'h05, 8'hFF);
        wr_reg(8'h10, 8'hFF);
        rd_expect(8'h10, 8'h00, "R10");
        rd_expect(8'h4E, 8'h02, "R10");
        rd_expect(8'h4F, 8'h01, "R10");
        // R11 read data hold
        cur_req = "R11";
        rd_expect(8'h4E, 8'h02, "R11");
        repeat (3) next();
        #5; check(rdata == 8'h02, "R11", rdata, 8'h02);
        next();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule